// File: doc/BRIEF.md
# Maskable Interrupt Request Unit with Cascade Acknowledge

This block collects six external maskable interrupt request lines and passes them to a processor core as a single request with a vector type. Each line goes through a two-stage synchronizer. Each line can then be set to level or edge detection, and each can be masked on its own. When several lines are active at once, a fixed priority picks the winner. The core sees one request signal. It takes a request by pulsing an acknowledge, and one clock later it receives a one-cycle valid strobe together with the vector type of the source it was granted.

The six lines are the request inputs numbered 0, 2, 3, 4, 5 and 6. On `irq_i`, bit 0 is input 0, bit 1 is input 2, and bit k (k ≥ 2) is input k+1. For an internal source the vector type is `BASE_TYPE` plus the input number.

The block also has a cascade mode, which hands input 0 to an external controller. In this mode the input-2 pin is no longer a request line and becomes an active-low acknowledge output. When the core acknowledges input 0, that output is pulled low for two clocks. The external controller places its vector type on `ext_type_i`, and the block samples it during the second low clock and returns it to the core.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Every request line passes through a two flip-flop synchronizer. For an unmasked level-mode line, `core_req_o` rises after exactly two rising clock edges following the line going high, and not after one.
- R2: Trigger bit 1 makes a line edge-triggered. A rising transition is held as pending even after the line returns low, and it stays pending until that source is acknowledged. Once acknowledged it no longer requests.
- R3: Trigger bit 0 makes a line level-triggered. A level request that drops before the acknowledge is lost, and `core_req_o` falls again.
- R4: A mask bit of 1 blocks its line, and a masked line never produces `core_req_o`.
- R5: Priority is fixed and the lowest input number wins. For an internal source the type is `BASE_TYPE` plus the input number, where the default base is 0x40 (input 0 gives 0x40, input 6 gives 0x46).
- R6: Handshake. A `core_ack_i` pulse while `core_req_o` is high is accepted. For an internal source, `type_vld_o` is high for exactly one cycle in the cycle after the acknowledge edge, with `core_type_o` valid. An acknowledge while no request is present is ignored.
- R7: With cascade enabled, bit 1 of `irq_i` is ignored as a request and `ack_oe_o` is high. With cascade disabled, `ack_oe_o` is low and `ack_n_o` is high.
- R8: With cascade enabled, acknowledging input 0 drives `ack_n_o` low for the two cycles after the acknowledge edge. `ext_type_i` is sampled during the second of those cycles, and `type_vld_o` follows in the next cycle carrying that type.
- R9: Configuration writes use `cfg_sel_i`. Code 0 writes the mask, code 1 writes the trigger modes, and code 2 writes the cascade enable from `cfg_wdata_i` bit 0.
- R10: After reset, every line is masked, every line is level-triggered and cascade is off. `core_req_o`, `type_vld_o` and `ack_oe_o` are low and `ack_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Request lines (bit 0 = input 0, bit 1 = input 2, bit k = input k+1) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 mask, 1 trigger mode, 2 cascade enable |
| cfg_wdata_i | input | NUM_SRC | Configuration write data |
| ext_type_i | input | TYPE_W | Vector type supplied by the external controller in cascade |
| core_req_o | output | 1 | Request to the core |
| core_ack_i | input | 1 | Acknowledge pulse from the core |
| type_vld_o | output | 1 | One-cycle strobe, vector type valid |
| core_type_o | output | TYPE_W | Vector type for the granted source |
| ack_n_o | output | 1 | Active-low acknowledge to the external controller |
| ack_oe_o | output | 1 | Drive enable for the input-2 pin used as the acknowledge |

## Verification
A level request reaches `core_req_o` after two clock edges, and an edge request reaches it after three, because of the extra edge-history register. The bench therefore waits at least four clocks after changing `irq_i` before it reads the request, and it probes the level case both one edge and two edges after the change. For an internal source, the valid strobe and type are due in the cycle after the acknowledge edge. For cascade, `ack_n_o` is low in the first and second cycles after the acknowledge edge and the type arrives in the third. The bench drives inputs and samples outputs on falling edges and checks each of those cycles individually.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_CAS1 = 2'd1,
        HS_CAS2 = 2'd2,
        HS_DONE = 2'd3
    } hs_state_e;

    localparam logic [1:0] CFG_SEL_MASK = 2'd0;
    localparam logic [1:0] CFG_SEL_TRIG = 2'd1;
    localparam logic [1:0] CFG_SEL_CASC = 2'd2;

    // Source index 0 is input 0; index k >= 1 is input k+1.
    function automatic int unsigned src_number(input int unsigned idx);
        return (idx == 0) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = async_i;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stage2;

endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] edge_mode_i,
    input  logic [WIDTH-1:0] clear_i,
    output logic [WIDTH-1:0] active_o
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] pend;
    } det_t;

    det_t s_d, s_q;
    logic [WIDTH-1:0] rise;

    always_comb begin
        s_d      = s_q;
        rise     = sync_i & ~s_q.prev;
        s_d.prev = sync_i;
        // a fresh edge wins over a clear in the same cycle
        s_d.pend = ((s_q.pend & ~clear_i) | rise) & edge_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
        assign active_o[i] = edge_mode_i[i] ? s_q.pend[i] : sync_i[i];
    end

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int unsigned WIDTH = 6,
    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] req_i,
    output logic             any_o,
    output logic [WIDTH-1:0] grant_o,
    output logic [IDX_W-1:0] idx_o
);

    logic [WIDTH:0] blocked;

    assign blocked[0] = 1'b0;
    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        assign grant_o[i]   = req_i[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req_i[i];
    end

    assign any_o = blocked[WIDTH];

    always_comb begin
        idx_o = '0;
        for (int unsigned i = 0; i < WIDTH; i++) begin
            if (grant_o[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_casc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 6,
    parameter int unsigned TYPE_W    = 8,
    parameter logic [7:0]  BASE_TYPE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [NUM_SRC-1:0] cfg_wdata_i,
    input  logic [TYPE_W-1:0] ext_type_i,
    output logic              core_req_o,
    input  logic              core_ack_i,
    output logic              type_vld_o,
    output logic [TYPE_W-1:0] core_type_o,
    output logic              ack_n_o,
    output logic              ack_oe_o
);

    localparam int unsigned IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned CASC_SRC = 0;
    localparam int unsigned ACK_PIN  = 1;

    typedef struct packed {
        hs_state_e         st;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] trig;
        logic              casc;
        logic [TYPE_W-1:0] typ;
        logic              ack_n;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [NUM_SRC-1:0] sync_lines;
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] eligible;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] clear;
    logic [NUM_SRC-1:0] pin_block;
    logic [IDX_W-1:0]   win_idx;
    logic               any_req;
    logic               take;
    logic [NUM_SRC-1:0] mask_q;

    irq_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_i),
        .sync_o  (sync_lines)
    );

    irq_detect #(.WIDTH(NUM_SRC)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_lines),
        .edge_mode_i (s_q.trig),
        .clear_i     (clear),
        .active_o    (active)
    );

    always_comb begin
        pin_block          = '0;
        pin_block[ACK_PIN] = s_q.casc;
    end

    assign eligible = active & ~s_q.mask & ~pin_block;

    irq_prio #(.WIDTH(NUM_SRC)) u_prio (
        .req_i   (eligible),
        .any_o   (any_req),
        .grant_o (grant),
        .idx_o   (win_idx)
    );

    assign take  = (s_q.st == HS_IDLE) && core_ack_i && any_req;
    assign clear = take ? grant : '0;

    always_comb begin
        s_d = s_q;

        if (cfg_we_i) begin
            unique case (cfg_sel_i)
                CFG_SEL_MASK: s_d.mask = cfg_wdata_i;
                CFG_SEL_TRIG: s_d.trig = cfg_wdata_i;
                CFG_SEL_CASC: s_d.casc = cfg_wdata_i[0];
                default:      ;
            endcase
        end

        unique case (s_q.st)
            HS_IDLE: begin
                if (take) begin
                    if (s_q.casc && grant[CASC_SRC]) begin
                        s_d.st    = HS_CAS1;
                        s_d.ack_n = 1'b0;
                    end else begin
                        s_d.st  = HS_DONE;
                        s_d.typ = TYPE_W'(BASE_TYPE) +
                                  TYPE_W'(src_number(int'(win_idx)));
                    end
                end
            end
            HS_CAS1: s_d.st = HS_CAS2;
            HS_CAS2: begin
                s_d.st    = HS_DONE;
                s_d.typ   = ext_type_i;
                s_d.ack_n = 1'b1;
            end
            HS_DONE: s_d.st = HS_IDLE;
            default: s_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= HS_IDLE;
            s_q.mask  <= '1;
            s_q.trig  <= '0;
            s_q.casc  <= 1'b0;
            s_q.typ   <= '0;
            s_q.ack_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask_q      = s_q.mask;
    assign core_req_o  = any_req && (s_q.st == HS_IDLE);
    assign type_vld_o  = (s_q.st == HS_DONE);
    assign core_type_o = s_q.typ;
    assign ack_n_o     = s_q.ack_n;
    assign ack_oe_o    = s_q.casc;

endmodule

// File: rtl/irq_casc_chk.sv
module irq_casc_chk #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned TYPE_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               core_req_o,
    input logic               type_vld_o,
    input logic [TYPE_W-1:0]  core_type_o,
    input logic               ack_n_o,
    input logic               ack_oe_o,
    input logic [TYPE_W-1:0]  ext_type_i,
    input logic [NUM_SRC-1:0] mask_q
);

    AST_ACK_ONLY_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_o |-> ack_oe_o); // R7

    AST_ACK_HOLDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |=> !ack_n_o); // R8

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n_o && !$past(ack_n_o)) |=> ack_n_o); // R8

    AST_EXT_TYPE_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (type_vld_o && !$past(ack_n_o)) |-> core_type_o == $past(ext_type_i)); // R8

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        type_vld_o |=> !type_vld_o); // R6

    AST_NO_REQ_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        type_vld_o |-> !core_req_o); // R6

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !core_req_o); // R4

endmodule

bind irq_cascade_ctrl irq_casc_chk #(.NUM_SRC(NUM_SRC), .TYPE_W(TYPE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_req_o  (core_req_o),
    .type_vld_o  (type_vld_o),
    .core_type_o (core_type_o),
    .ack_n_o     (ack_n_o),
    .ack_oe_o    (ack_oe_o),
    .ext_type_i  (ext_type_i),
    .mask_q      (mask_q)
);

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb;

    localparam int unsigned NS = 6;
    localparam int unsigned TW = 8;
    localparam logic [7:0] EXT = 8'hA7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [NS-1:0] cfg_wdata = '0;
    logic [TW-1:0] ext_type = EXT;
    logic          core_req;
    logic          core_ack = 1'b0;
    logic          type_vld;
    logic [TW-1:0] core_type;
    logic          ack_n;
    logic          ack_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_cascade_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .irq_i (irq),
        .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel), .cfg_wdata_i (cfg_wdata),
        .ext_type_i (ext_type), .core_req_o (core_req), .core_ack_i (core_ack),
        .type_vld_o (type_vld), .core_type_o (core_type),
        .ack_n_o (ack_n), .ack_oe_o (ack_oe)
    );

    // {mask, trig, casc, irq, exp_req, exp_cascade_path, exp_type}
    localparam int VW = 6 + 6 + 1 + 6 + 1 + 1 + 8;
    localparam int NV = 8;
    localparam logic [VW-1:0] VEC [NV] = '{
        {6'b000000, 6'b000000, 1'b0, 6'b000001, 1'b1, 1'b0, 8'h40}, // R5 input 0
        {6'b000000, 6'b000000, 1'b0, 6'b110100, 1'b1, 1'b0, 8'h43}, // R5 lowest wins
        {6'b000100, 6'b000000, 1'b0, 6'b110100, 1'b1, 1'b0, 8'h45}, // R4 masked winner
        {6'b111111, 6'b000000, 1'b0, 6'b111111, 1'b0, 1'b0, 8'h00}, // R4 all masked
        {6'b000000, 6'b000000, 1'b1, 6'b000010, 1'b0, 1'b0, 8'h00}, // R7 pin 2 ignored
        {6'b000000, 6'b000000, 1'b1, 6'b000011, 1'b1, 1'b1, EXT  }, // R8 cascade
        {6'b000000, 6'b111111, 1'b0, 6'b100000, 1'b1, 1'b0, 8'h46}, // R2 edge input 6
        {6'b000001, 6'b000000, 1'b1, 6'b000001, 1'b0, 1'b0, 8'h00}  // R4 masked cascade
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [NS-1:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ack();
        core_ack = 1'b1;
        tick();
        core_ack = 1'b0;
    endtask

    task automatic drain();
        repeat (4) tick();
        for (int k = 0; k < 8; k++) begin
            if (core_req) begin
                pulse_ack();
                repeat (4) tick();
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(10 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        // R10 reset state
        check(core_req == 1'b0, "R10 core_req after reset", core_req, 0);
        check(type_vld == 1'b0, "R10 type_vld after reset", type_vld, 0);
        check(ack_n == 1'b1 && ack_oe == 1'b0, "R10 ack pins after reset", {ack_n, ack_oe}, 2'b10);
        rst_n = 1'b1;
        tick();
        irq = 6'b111111;
        repeat (4) tick();
        check(core_req == 1'b0, "R10 lines masked out of reset", core_req, 0);
        irq = '0;
        repeat (4) tick();

        // vector table walk (R9 encodings used for every config write)
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            cfg_write(2'd0, e[28:23]);
            cfg_write(2'd1, e[22:17]);
            cfg_write(2'd2, {5'b0, e[16]});
            check(ack_oe == e[16], "R7 R9 ack_oe follows cascade", ack_oe, e[16]);
            irq = e[15:10];
            repeat (4) tick();
            check(core_req == e[9], $sformatf("R4 R5 R7 vec%0d req", v), core_req, e[9]);
            if (e[9]) begin
                pulse_ack();
                if (e[8]) begin
                    check(ack_n == 1'b0, "R8 ack low cycle 1", ack_n, 0);
                    tick();
                    check(ack_n == 1'b0, "R8 ack low cycle 2", ack_n, 0);
                    tick();
                    check(ack_n == 1'b1, "R8 ack released", ack_n, 1);
                end
                check(type_vld == 1'b1, $sformatf("R6 vec%0d vld", v), type_vld, 1);
                check(core_type == e[7:0], $sformatf("R5 R8 vec%0d type", v), core_type, e[7:0]);
                tick();
                check(type_vld == 1'b0, "R6 vld single cycle", type_vld, 0);
            end
            irq = '0;
            drain();
        end

        // R1 synchronizer latency, level mode
        cfg_write(2'd2, '0);
        cfg_write(2'd1, '0);
        cfg_write(2'd0, '0);
        irq = 6'b010000;
        tick();
        check(core_req == 1'b0, "R1 not visible after one edge", core_req, 0);
        tick();
        check(core_req == 1'b1, "R1 visible after two edges", core_req, 1);

        // R3 level request dropping before acknowledge is lost
        irq = '0;
        repeat (4) tick();
        check(core_req == 1'b0, "R3 dropped level lost", core_req, 0);

        // R6 acknowledge with nothing pending is ignored
        pulse_ack();
        check(type_vld == 1'b0, "R6 idle ack ignored", type_vld, 0);

        // R2 edge pending survives line drop, cleared by acknowledge
        cfg_write(2'd1, 6'b000100);
        irq = 6'b000100;
        repeat (3) tick();
        irq = '0;
        repeat (6) tick();
        check(core_req == 1'b1, "R2 edge pending held", core_req, 1);
        pulse_ack();
        check(type_vld == 1'b1 && core_type == 8'h43, "R2 edge served type", core_type, 8'h43);
        repeat (3) tick();
        check(core_req == 1'b0, "R2 pending cleared by ack", core_req, 0);

        // R2 a held edge line does not re-request after ack
        irq = 6'b000100;
        repeat (5) tick();
        pulse_ack();
        repeat (4) tick();
        check(core_req == 1'b0, "R2 held line single event", core_req, 0);
        irq = '0;
        repeat (4) tick();

        finish_run();
    end

endmodule